// File: doc/BRIEF.md
# Delayed Completion Interrupt Coalescer

The block sits beside a copy engine and turns its per-descriptor completion pulses into a single interrupt. Software does not have to take an interrupt for every descriptor. It can hold the interrupt back until enough completions have piled up, or until the oldest unserviced completion has waited long enough, whichever comes first. A free prescaler, sized from the clock frequency, measures the wait in fixed ticks of `TICK_US` microseconds. The prescaler stays parked while nothing is pending, so every measurement starts from the first pending completion.

Three registers are reachable on a simple single-cycle write and combinational read bus:

| Offset | Register | Contents |
|---|---|---|
| `0x0C` | delay control | mode and thresholds |
| `0x20` | status | sticky done flag, cleared by writing 1, and a read-only copy of the pending count |
| `0x28` | mask | interrupt enable |

The interrupt line is the done flag gated by the enable bit. During service, software drops the enable bit, clears the flag and then sets the enable bit again.

Top module: `irq_coalescer`

## Requirements
- R1: After reset, `irq` is low and the mask and status registers read 0. The delay control register reads `0x0000_9414`: delayed mode on, count threshold 20, time threshold 20.
- R2: The delay control register holds the delayed-mode enable in bit 15, the count threshold in bits [14:8] and the time threshold in bits [6:0]. Bit 7 and bits [31:16] are ignored on write and read as 0.
- R3: With delayed mode off (bit 15 = 0), every completion pulse sets the done flag at the clock edge that samples the pulse.
- R4: With delayed mode on, the done flag is set on the edge after the pending count first exceeds the count threshold. The count rises by one on each edge that samples a completion pulse.
- R5: With delayed mode on, the pending time rises by one every `CLK_MHZ*TICK_US` cycles, counted from the edge that registers the first pending completion. The done flag is set on the edge after the pending time first exceeds the time threshold.
- R6: The done flag is status bit 16. It stays set until a write to the status register with bit 16 = 1 clears it. A status write with bit 16 = 0 has no effect.
- R7: `irq` equals the done flag ANDed with mask bit 16. The flag is set and reads back at status bit 16 whether or not the mask bit is set.
- R8: Clearing the done flag resets the pending count, the pending time and the prescaler. A completion sampled on the same edge as the clear leaves the pending count at 1 for the next interval.
- R9: The pending count saturates at 127 and does not wrap. It reads back at status bits [6:0].
- R10: The pending time saturates at 255, so a time threshold of 127 can still fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_in | input | 1 | One-cycle completion pulse per finished descriptor |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with `CLK_MHZ = 1` and `TICK_US = 5`, so one time tick lasts five cycles. With that setting, the time threshold can be swept and its saturating top value of 127 reached within a few hundred cycles. Latency to the interrupt is swept over count thresholds 0 to 6 with three pulse spacings, and over time thresholds 0 to 7. The count-saturation edge at threshold 126 and the same-cycle clear-with-pulse case are also covered. Each expected latency is derived from the edge arithmetic stated in the requirements.

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int CLK_MHZ  = 50,
  parameter int TICK_US  = 20,
  parameter int ADDR_W   = 8,
  parameter int DLY_OFS  = 'h0C,
  parameter int STAT_OFS = 'h20,
  parameter int MASK_OFS = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int TICK_CYC = CLK_MHZ * TICK_US;
  localparam int PRE_W    = $clog2(TICK_CYC + 1);
  localparam logic [6:0] CNT_MAX  = 7'h7F;
  localparam logic [7:0] TIME_MAX = 8'hFF;

  logic             dly_en;
  logic [6:0]       cnt_thr, time_thr;
  logic             done_st, done_en;
  logic [6:0]       pend_cnt;
  logic [7:0]       pend_time;
  logic [PRE_W-1:0] pre;

  wire sel_dly  = reg_addr == ADDR_W'(DLY_OFS);
  wire sel_stat = reg_addr == ADDR_W'(STAT_OFS);
  wire sel_mask = reg_addr == ADDR_W'(MASK_OFS);

  wire clr     = reg_wr && sel_stat && reg_wdata[16];
  wire tick    = pre == PRE_W'(TICK_CYC - 1);
  wire pending = pend_cnt != 7'd0;
  wire instant = !dly_en && done_in;
  wire fire    = dly_en && !clr &&
                 ((pend_cnt > cnt_thr) || (pend_time > {1'b0, time_thr}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_en   <= 1'b1;
      cnt_thr  <= 7'd20;
      time_thr <= 7'd20;
      done_en  <= 1'b0;
    end else if (reg_wr) begin
      if (sel_dly) begin
        dly_en   <= reg_wdata[15];
        cnt_thr  <= reg_wdata[14:8];
        time_thr <= reg_wdata[6:0];
      end
      if (sel_mask) done_en <= reg_wdata[16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_st <= 1'b0;
    else        done_st <= (done_st && !clr) || fire || instant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt  <= '0;
      pend_time <= '0;
      pre       <= '0;
    end else if (clr) begin
      pend_cnt  <= done_in ? 7'd1 : 7'd0;
      pend_time <= '0;
      pre       <= '0;
    end else begin
      if (done_in && pend_cnt != CNT_MAX) pend_cnt <= pend_cnt + 7'd1;
      if (!pending || tick) pre <= '0;
      else                  pre <= pre + PRE_W'(1);
      if (pending && tick && pend_time != TIME_MAX) pend_time <= pend_time + 8'd1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_dly)  reg_rdata = {16'b0, dly_en, cnt_thr, 1'b0, time_thr};
    if (sel_stat) reg_rdata = {15'b0, done_st, 9'b0, pend_cnt};
    if (sel_mask) reg_rdata = {15'b0, done_en, 16'b0};
  end

  assign irq = done_st & done_en;

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_st && !clr) |=> done_st);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !instant) |=> !done_st);
  a_r3_instant: assert property (@(posedge clk) disable iff (!rst_n)
    instant |=> done_st);
  a_r4_count_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_en && !clr && pend_cnt > cnt_thr) |=> done_st);
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> pend_cnt >= $past(pend_cnt));
  a_r5_idle_timer: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> (pend_time == 8'd0 && pre == '0));
endmodule

// File: tb/irq_coalescer_tb_top.sv
module irq_coalescer_tb_top;
  localparam int TC = 5;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int vectors = 0;
  int fails = 0;

  irq_coalescer #(.CLK_MHZ(1), .TICK_US(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .done_in(done_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit pulse = 1'b0);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; done_in = pulse;
    @(negedge clk);
    reg_wr = 1'b0; done_in = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic measure(input int cthr, input int tthr, input bit dly, input int gap,
                         input int npulses, input int limit, output int first);
    int sent;
    wr(8'h0C, {16'b0, dly, 7'(cthr), 1'b0, 7'(tthr)});
    wr(8'h20, 32'h0001_0000);
    first = -1;
    sent = 0;
    for (int c = 0; c <= limit; c++) begin
      if (irq && first < 0) first = c;
      done_in = (c % (gap + 1) == 0) && (sent < npulses);
      if (done_in) sent++;
      @(negedge clk);
    end
    done_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check(irq == 1'b0, "R1 irq", irq, 0);
    rd(8'h0C, d); check(d == 32'h9414, "R1 ctrl", d, 32'h9414);
    rd(8'h20, d); check(d == 0, "R1 status", d, 0);
    rd(8'h28, d); check(d == 0, "R1 mask", d, 0);

    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); check(d == 32'hFF7F, "R2 ctrl all ones", d, 32'hFF7F);
    wr(8'h0C, 32'h0001_2345);
    rd(8'h0C, d); check(d == 32'h2345, "R2 ctrl pattern", d, 32'h2345);

    // R7: mask off, status still set
    wr(8'h28, 32'h0);
    measure(0, 127, 1'b1, 0, 1, 5, f);
    check(f < 0, "R7 masked irq", f, -1);
    rd(8'h20, d); check(d[16] == 1'b1, "R7 status set while masked", d[16], 1);
    wr(8'h28, 32'h0001_0000);
    check(irq == 1'b1, "R7 irq after unmask", irq, 1);
    // R6: write 0 no effect, write 1 clears
    wr(8'h20, 32'h0000_FFFF);
    rd(8'h20, d); check(d[16] == 1'b1, "R6 write0 ignored", d[16], 1);
    wr(8'h20, 32'h0001_0000);
    rd(8'h20, d); check(d[16] == 1'b0, "R6 w1c", d[16], 0);
    check(irq == 1'b0, "R6 irq after clear", irq, 0);

    measure(20, 20, 1'b0, 0, 1, 10, f);
    check(f == 1, "R3 immediate", f, 1);

    for (int ct = 0; ct <= 6; ct++)
      for (int g = 0; g <= 2; g++) begin
        measure(ct, 127, 1'b1, g, ct + 1, 60, f);
        check(f == ct * (g + 1) + 2, "R4 count latency", f, ct * (g + 1) + 2);
      end
    measure(126, 127, 1'b1, 0, 200, 200, f);
    check(f == 128, "R4 threshold 126", f, 128);

    for (int t = 0; t <= 7; t++) begin
      measure(127, t, 1'b1, 0, 1, 60, f);
      check(f == (t + 1) * TC + 2, "R5 time latency", f, (t + 1) * TC + 2);
    end
    measure(127, 127, 1'b1, 0, 1, 700, f);
    check(f == 128 * TC + 2, "R10 time saturation reach", f, 128 * TC + 2);

    measure(127, 127, 1'b1, 0, 150, 160, f);
    rd(8'h20, d);
    check(d[6:0] == 7'd127, "R9 count saturates", d[6:0], 127);
    check(f < 0 && d[16] == 1'b0, "R9 no fire at 127", d[16], 0);

    // R8: clear alone resets count; clear with pulse carries one
    measure(1, 127, 1'b1, 0, 1, 3, f);
    wr(8'h20, 32'h0001_0000);
    rd(8'h20, d); check(d[6:0] == 7'd0, "R8 clear resets count", d[6:0], 0);
    measure(1, 127, 1'b1, 0, 1, 3, f);
    wr(8'h20, 32'h0001_0000, 1'b1);
    rd(8'h20, d); check(d == 32'd1, "R8 same-cycle pulse carried", d, 1);
    done_in = 1'b1; @(negedge clk); done_in = 1'b0;
    @(negedge clk);
    check(irq == 1'b1, "R8 fires on next pulse", irq, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule